// File: doc/BRIEF.md
# Serial Host Control Register Port

This block lets an external host configure a digital audio transmitter over a four-line serial link: an active-low select, a serial clock, a data line into the block and a data line out of it. It holds eighteen 8-bit control registers (addresses 00h to 11h): a clock and format control word, a validity and sample-rate word, four channel-status bytes for each of two channels, and four user-data bytes for each channel. The register contents are presented as decoded fields and 32-bit buffers to the audio logic that uses them.

Every access is one frame of 24 serial clocks while select is low. The frame begins with a 2-bit device code that must be binary 11, then five padding bits whose values are ignored, then a direction flag (1 writes, 0 reads), an 8-bit register address and 8 data bits, all sent most significant bit first. On a read, the block drives the register value on the output line during the last eight clocks and keeps the line released at every other time; the output enable is brought out so the pad can be tri-stated. The serial lines are sampled with the block's own fast clock, so the serial clock may run at up to 5 MHz with no relation to it.

Top module: `hostctl_port`

## Requirements
- R1: After rst_n is low on a clock edge, the control word reads 83h (crc_en=1, fmt_sel=0, clk_sel=0, mute=1, run=1), the rate word reads 00h, channel-status bytes 0..3 are 04h, 00h, 10h, 02h for channel A and 04h, 00h, 20h, 02h for channel B, all user-data bytes are 00h, and sdo_oe is 0.
- R2: A frame with device code 11 and direction 1 stores its data byte in the addressed register, and the change appears when the 24th bit is taken in. The control word maps crc_en to bit 7, fmt_sel to bits 6:4, clk_sel to bits 3:2, mute to bit 1 and run to bit 0; the rate word maps invalid to bit 4 and rate_code to bits 3:0; addresses 02h-05h, 06h-09h, 0Ah-0Dh and 0Eh-11h hold bytes 0..3 of cs_a, cs_b, ud_a and ud_b, byte 0 in bits 7:0.
- R3: A frame whose device code is not 11 writes nothing and never asserts sdo_oe.
- R4: A frame with device code 11 and direction 0 presents the addressed register on sdo, bit 7 first, one bit per serial clock through the last eight clocks of the frame, with the new bit changing after the falling serial clock; sdo_oe is 0 through the first 16 bits.
- R5: sdo_oe returns to 0 when select goes high.
- R6: A write frame cut short by select rising before the 24th bit changes no register.
- R7: Writes to addresses 12h and above change no register, and reads of them return 00h.
- R8: Bits 7:5 of the rate word are not stored and always read as 0.
- R9: While pdn_n is low all registers return to the R1 values.
- R10: The five padding bits have no effect on the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to sample the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| pdn_n | input | 1 | Active-low power-down; restores register defaults |
| cs_n | input | 1 | Serial select, active low, frames an access |
| sck | input | 1 | Serial clock, data taken on its rising edge |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | Drive enable for the sdo pad; 0 means high impedance |
| crc_en | output | 1 | CRC enable bit of the control word |
| fmt_sel | output | 3 | Audio format select |
| clk_sel | output | 2 | Master clock ratio select |
| mute | output | 1 | Mute bit of the control word |
| run | output | 1 | Run bit; 0 holds the transmitter in reset |
| invalid | output | 1 | Validity flag, 1 marks samples invalid |
| rate_code | output | 4 | Sample-rate code |
| cs_a | output | 32 | Channel-status bytes 0..3, channel A |
| cs_b | output | 32 | Channel-status bytes 0..3, channel B |
| ud_a | output | 32 | User-data bytes 0..3, channel A |
| ud_b | output | 32 | User-data bytes 0..3, channel B |

## Verification
Each serial edge passes two synchroniser flops and an edge detector, so a write becomes visible on the field outputs about four block clocks after the rising serial clock that carries the last data bit, a read bit appears on sdo about four clocks after the falling serial clock, and sdo_oe falls about four clocks after select rises. The bench holds every serial level for sixteen block clocks, samples sdo just before each rising serial clock and checks register fields and sdo_oe eight or more clocks after select rises, so every result has long settled when it is read. Register contents are checked both through the field outputs and by serial read-back, which also covers the output timing of each data bit.

// File: rtl/hostctl_pkg.sv
// Package: shared frame layout and register map constants for the serial
// host control port. Assumes an 8-bit address and 8-bit data frame.
package hostctl_pkg;

    localparam int CHIP_W     = 2;
    localparam int PAD_W      = 5;
    localparam int AW         = 8;
    localparam int DW         = 8;
    localparam int NREG       = 18;
    localparam logic [CHIP_W-1:0] CHIP_ID = 2'b11;

    // Bit indices within the frame (index of the bit being taken in).
    localparam int CHIP_LAST  = CHIP_W - 1;
    localparam int RW_POS     = CHIP_W + PAD_W;
    localparam int ADDR_LAST  = RW_POS + AW;
    localparam int DATA_FIRST = ADDR_LAST + 1;
    localparam int DATA_LAST  = ADDR_LAST + DW;
    localparam int FRAME_BITS = DATA_LAST + 1;

    localparam int RATE_REG   = 1;

    // Reset value of each register.
    function automatic logic [DW-1:0] reg_default(input int unsigned idx);
        case (idx)
            0:       return 8'h83;
            2, 6:    return 8'h04;
            4:       return 8'h10;
            8:       return 8'h20;
            5, 9:    return 8'h02;
            default: return 8'h00;
        endcase
    endfunction

    // Bits that are actually stored in each register.
    function automatic logic [DW-1:0] reg_mask(input int unsigned idx);
        if (idx == RATE_REG) return 8'h1F;
        return 8'hFF;
    endfunction

endpackage

// File: rtl/hostctl_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes each input bit is independent and stays stable for several clocks.
module hostctl_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the raw inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= d;
            end
        end else begin : g_next
            // Pass the sample one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/hostctl_frame.sv
// Module: serial frame engine. Counts rising serial clocks inside a select
// window, collects device code, direction, address and data, issues a
// one-cycle write strobe and shifts read data out on falling serial clocks.
// Assumes synchronised inputs and a serial clock much slower than clk.
module hostctl_frame
    import hostctl_pkg::*;
#(
    parameter int NUM_REGS = NREG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csn_s,
    input  logic          sck_s,
    input  logic          sdi_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic          sdo,
    output logic          sdo_oe
);

    localparam int CW = $clog2(FRAME_BITS + 1);

    logic          sck_d;
    logic          rise;
    logic          fall;
    logic [CW-1:0] bit_cnt;
    logic [6:0]    sh_in;
    logic [DW-1:0] cur_byte;
    logic          chip_ok_q;
    logic          rw_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] sh_out;
    logic          oe_q;
    logic          we_q;
    logic [DW-1:0] wdata_q;

    assign rise     = sck_s & ~sck_d;
    assign fall     = ~sck_s & sck_d;
    assign cur_byte = {sh_in, sdi_s};
    assign rd_addr  = cur_byte;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Frame sequencing: bit count, field capture, write strobe, read launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            sh_in     <= '0;
            chip_ok_q <= 1'b0;
            rw_q      <= 1'b0;
            addr_q    <= '0;
            sh_out    <= '0;
            oe_q      <= 1'b0;
            we_q      <= 1'b0;
            wdata_q   <= '0;
        end else begin
            we_q <= 1'b0;
            if (csn_s) begin
                bit_cnt <= '0;
                oe_q    <= 1'b0;
            end else begin
                if (rise && bit_cnt < CW'(FRAME_BITS)) begin
                    sh_in   <= {sh_in[5:0], sdi_s};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == CW'(CHIP_LAST))
                        chip_ok_q <= ({sh_in[0], sdi_s} == CHIP_ID);
                    if (bit_cnt == CW'(RW_POS))
                        rw_q <= sdi_s;
                    if (bit_cnt == CW'(ADDR_LAST)) begin
                        addr_q <= cur_byte;
                        if (chip_ok_q && !rw_q) begin
                            oe_q   <= 1'b1;
                            sh_out <= rd_data;
                        end
                    end
                    if (bit_cnt == CW'(DATA_LAST) && chip_ok_q && rw_q
                        && addr_q < AW'(NUM_REGS)) begin
                        we_q    <= 1'b1;
                        wdata_q <= cur_byte;
                    end
                end
                if (fall && oe_q && bit_cnt > CW'(DATA_FIRST)
                    && bit_cnt < CW'(FRAME_BITS))
                    sh_out <= {sh_out[DW-2:0], 1'b0};
            end
        end
    end

    assign we     = we_q;
    assign waddr  = addr_q;
    assign wdata  = wdata_q;
    assign sdo    = oe_q & sh_out[DW-1];
    assign sdo_oe = oe_q;

    // R5: the output is released once select is seen high.
    p_release_on_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !sdo_oe);

    // R4: the output is driven only in the data phase of a frame.
    p_drive_in_data_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (bit_cnt >= CW'(DATA_FIRST)));

    // R6: a write strobe only follows a cycle with select low.
    p_no_write_after_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !$past(csn_s));

endmodule

// File: rtl/hostctl_regs.sv
// Module: control register bank with per-register defaults and stored-bit
// masks, one write port and one combinational read port. Power-down and
// reset both restore defaults. Assumes at most one write per cycle.
module hostctl_regs
    import hostctl_pkg::*;
#(
    parameter int NUM_REGS = NREG
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pdn_n,
    input  logic                         we,
    input  logic [AW-1:0]                waddr,
    input  logic [DW-1:0]                wdata,
    input  logic [AW-1:0]                raddr,
    output logic [DW-1:0]                rdata,
    output logic [NUM_REGS-1:0][DW-1:0]  regs
);

    localparam int IW = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0][DW-1:0] regs_q;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // Hold one register: default on reset or power-down, else take writes.
        always_ff @(posedge clk) begin
            if (!rst_n || !pdn_n)
                regs_q[i] <= reg_default(i);
            else if (we && waddr == AW'(i))
                regs_q[i] <= wdata & reg_mask(i);
        end
    end

    // Read port: unimplemented addresses return zero.
    always_comb begin
        if (raddr < AW'(NUM_REGS)) rdata = regs_q[raddr[IW-1:0]];
        else                       rdata = '0;
    end

    assign regs = regs_q;

    // R7: no write strobe reaches the bank for an unimplemented address.
    p_write_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (waddr < AW'(NUM_REGS)));

    // R2: a strobed write is held in the addressed register next cycle.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && pdn_n) |=> regs_q[$past(waddr[IW-1:0])]
                          == ($past(wdata) & reg_mask($past(waddr[IW-1:0]))));

    // R9: power-down restores the control and rate words.
    p_defaults_on_powerdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_n |=> (regs_q[0] == 8'h83 && regs_q[RATE_REG] == 8'h00));

endmodule

// File: rtl/hostctl_port.sv
// Module: top of the serial host control port. Synchronises the serial
// lines, runs the frame engine against the register bank and breaks the
// registers out into named fields and 32-bit buffers.
// Assumes sck at most 5 MHz and clk at least twenty times faster.
module hostctl_port
    import hostctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pdn_n,
    input  logic        cs_n,
    input  logic        sck,
    input  logic        sdi,
    output logic        sdo,
    output logic        sdo_oe,
    output logic        crc_en,
    output logic [2:0]  fmt_sel,
    output logic [1:0]  clk_sel,
    output logic        mute,
    output logic        run,
    output logic        invalid,
    output logic [3:0]  rate_code,
    output logic [31:0] cs_a,
    output logic [31:0] cs_b,
    output logic [31:0] ud_a,
    output logic [31:0] ud_b
);

    localparam int BUF_BYTES = 4;
    localparam int NUM_BUFS  = 4;
    localparam int BUF_BASE  = 2;

    logic [2:0]                  pins_s;
    logic                        we;
    logic [AW-1:0]               waddr;
    logic [DW-1:0]               wdata;
    logic [AW-1:0]               raddr;
    logic [DW-1:0]               rdata;
    logic [NREG-1:0][DW-1:0]     regs;
    logic [NUM_BUFS-1:0][31:0]   bufs;

    hostctl_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, sdi}),
        .q     (pins_s)
    );

    hostctl_frame #(
        .NUM_REGS (NREG)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .csn_s   (pins_s[2]),
        .sck_s   (pins_s[1]),
        .sdi_s   (pins_s[0]),
        .rd_data (rdata),
        .rd_addr (raddr),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe)
    );

    hostctl_regs #(
        .NUM_REGS (NREG)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .pdn_n (pdn_n),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata),
        .regs  (regs)
    );

    assign crc_en    = regs[0][7];
    assign fmt_sel   = regs[0][6:4];
    assign clk_sel   = regs[0][3:2];
    assign mute      = regs[0][1];
    assign run       = regs[0][0];
    assign invalid   = regs[RATE_REG][4];
    assign rate_code = regs[RATE_REG][3:0];

    for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
        for (genvar k = 0; k < BUF_BYTES; k++) begin : g_byte
            assign bufs[b][k*DW +: DW] = regs[BUF_BASE + b*BUF_BYTES + k];
        end
    end

    assign cs_a = bufs[0];
    assign cs_b = bufs[1];
    assign ud_a = bufs[2];
    assign ud_b = bufs[3];

endmodule

// File: tb/hostctl_port_bench.sv
module hostctl_port_bench;

    localparam int H = 16;  // block clocks per serial half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pdn_n = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe, crc_en, mute, run, invalid;
    logic [2:0] fmt_sel;
    logic [1:0] clk_sel;
    logic [3:0] rate_code;
    logic [31:0] cs_a, cs_b, ud_a, ud_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hostctl_port u_hostctl_port (
        .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .cs_n(cs_n), .sck(sck),
        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .crc_en(crc_en),
        .fmt_sel(fmt_sel), .clk_sel(clk_sel), .mute(mute), .run(run),
        .invalid(invalid), .rate_code(rate_code), .cs_a(cs_a), .cs_b(cs_b),
        .ud_a(ud_a), .ud_b(ud_b)
    );

    // Write then read back: {address, write data, expected read value}.
    localparam logic [23:0] VEC [10] = '{
        {8'h00, 8'h5A, 8'h5A},
        {8'h01, 8'hFF, 8'h1F},
        {8'h02, 8'hA5, 8'hA5},
        {8'h05, 8'h3C, 8'h3C},
        {8'h09, 8'h81, 8'h81},
        {8'h0A, 8'h11, 8'h11},
        {8'h11, 8'hEE, 8'hEE},
        {8'h12, 8'h77, 8'h00},
        {8'h7F, 8'h12, 8'h00},
        {8'hFF, 8'h34, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One serial access of nbits bits; reports read data and enable history.
    task automatic xfer(input logic [1:0] chip, input logic [4:0] pad,
                        input logic rw, input logic [7:0] addr,
                        input logic [7:0] data, input int nbits,
                        output logic [7:0] rdv, output logic oe_pre,
                        output logic oe_all, output logic oe_any);
        logic [23:0] frame;
        frame  = {chip, pad, rw, addr, data};
        rdv    = '0;
        oe_pre = 1'b0;
        oe_all = 1'b1;
        oe_any = 1'b0;
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = frame[23-i];
            repeat (H) @(negedge clk);
            if (i >= 16) begin
                rdv[23-i] = sdo;
                oe_all &= sdo_oe;
                oe_any |= sdo_oe;
            end else begin
                oe_pre |= sdo_oe;
            end
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] data);
        logic [7:0] r; logic a, b, c;
        xfer(2'b11, 5'h00, 1'b1, addr, data, 24, r, a, b, c);
    endtask

    task automatic rd(input logic [7:0] addr, output logic [7:0] val);
        logic a, b, c;
        xfer(2'b11, 5'h00, 1'b0, addr, 8'h00, 24, val, a, b, c);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic oe_pre, oe_all, oe_any;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset values at the ports
        check("R1 control word", {crc_en, fmt_sel, clk_sel, mute, run}, 32'h83);
        check("R1 rate word", {invalid, rate_code}, 32'h0);
        check("R1 cs_a", cs_a, 32'h0210_0004);
        check("R1 cs_b", cs_b, 32'h0220_0004);
        check("R1 user data", ud_a | ud_b, 32'h0);
        check("R1 sdo_oe", sdo_oe, 32'h0);

        // R4: default read-back with enable only in data phase
        xfer(2'b11, 5'h00, 1'b0, 8'h08, 8'h00, 24, v, oe_pre, oe_all, oe_any);
        check("R4 read default cs_b byte2", v, 32'h20);
        check("R4 no drive before data phase", oe_pre, 32'h0);
        check("R4 drive in data phase", oe_all, 32'h1);
        check("R5 released after select rises", sdo_oe, 32'h0);

        // Table: write then read back each entry (R2, R7, R8)
        foreach (VEC[k]) begin
            wr(VEC[k][23:16], VEC[k][15:8]);
            rd(VEC[k][23:16], v);
            check("R2/R7/R8 readback", v, {24'h0, VEC[k][7:0]});
        end
        check("R2 fields from control word 5A",
              {crc_en, fmt_sel, clk_sel, mute, run}, 32'h5A);
        check("R8 rate fields", {invalid, rate_code}, 32'h1F);
        check("R2 cs_a byte0 and byte3", cs_a, 32'h3C10_00A5);
        check("R2 cs_b byte3", cs_b, 32'h8120_0004);
        check("R2 ud_a byte0", ud_a, 32'h0000_0011);
        check("R7 ud_b only byte3 changed", ud_b, 32'hEE00_0000);

        // R3: wrong device code, write ignored and no drive on read
        xfer(2'b10, 5'h00, 1'b1, 8'h03, 8'h99, 24, v, oe_pre, oe_all, oe_any);
        check("R3 write ignored", cs_a, 32'h3C10_00A5);
        xfer(2'b01, 5'h00, 1'b0, 8'h00, 8'h00, 24, v, oe_pre, oe_all, oe_any);
        check("R3 no drive", oe_pre | oe_any, 32'h0);

        // R6: write aborted after 20 bits
        xfer(2'b11, 5'h00, 1'b1, 8'h0B, 8'h66, 20, v, oe_pre, oe_all, oe_any);
        check("R6 aborted write", ud_a, 32'h0000_0011);

        // R10: padding bits all ones
        xfer(2'b11, 5'h1F, 1'b1, 8'h0C, 8'h42, 24, v, oe_pre, oe_all, oe_any);
        check("R10 padding ignored on write", ud_a, 32'h0042_0011);
        xfer(2'b11, 5'h15, 1'b0, 8'h0C, 8'h00, 24, v, oe_pre, oe_all, oe_any);
        check("R10 padding ignored on read", v, 32'h42);

        // R9: power-down restores defaults
        pdn_n = 1'b0;
        repeat (3) @(negedge clk);
        pdn_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 control word", {crc_en, fmt_sel, clk_sel, mute, run}, 32'h83);
        check("R9 rate word", {invalid, rate_code}, 32'h0);
        check("R9 cs_a", cs_a, 32'h0210_0004);
        check("R9 cs_b", cs_b, 32'h0220_0004);
        check("R9 user data", ud_a | ud_b, 32'h0);
        rd(8'h04, v);
        check("R9 serial read cs_a byte2", v, 32'h10);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule